// File: doc/BRIEF.md
# Line Successive Cancellation Polar Decoder

This block recovers the eight message bits of one polar codeword from eight signed fixed-point channel log-likelihood ratios. Decoding follows successive cancellation: bit 0 is decided first, then bit 1, and so on up to bit 7. Each decision feeds partial sums that steer later combining steps. A single row of four shared processing elements performs every combining step. Each element is either a min-sum check combine (f) or a sign-controlled add/subtract (g). Multiplexers route each element to the register tree level that is active in the current cycle.

The channel LLRs, in natural index order, and a mask of frozen bit positions are captured on a one-cycle `load` strobe. A controller then walks the fixed 14-step stage schedule. It is built as a state machine with four states: `S_IDLE` (waiting), `S_FSTEP` (an f step at the current stage), `S_GSTEP` (a g step at the current stage) and `S_FIN` (one-cycle completion). Its transitions are:

- load from any state to `S_FSTEP` at the stage nearest the channel;
- `S_FSTEP`/`S_GSTEP` above stage 0 to `S_FSTEP` one stage lower;
- `S_FSTEP`/`S_GSTEP` at stage 0 with bits still left to `S_GSTEP`, at the stage given by the number of trailing zeros of the next bit index;
- `S_FSTEP`/`S_GSTEP` at stage 0 after the last bit to `S_FIN`;
- `S_FIN` to `S_IDLE`.

The code relation assumed is x_j = XOR of u_k over every k whose binary index contains every set bit of j. Channel LLR i belongs to code bit x_i, and a positive LLR favours 0.

Top module: `sc_line_dec`

## Requirements
- R1: An f step yields sign(a)·sign(b)·min(|a|,|b|). Here a is the lower-indexed input (channel j or tree node j) and b is the input half a span above it; a zero magnitude gives 0.
- R2: A g step yields b + a when the partial sum for that node is 0 and b − a when it is 1. The partial sum is the XOR of the already decided bits of the sibling sub-block, selected by the code relation above.
- R3: A bit whose position is set in the frozen mask (bit i of `frozen` for u_i) is output as 0. Any other bit is 1 exactly when its final LLR is zero or negative.
- R4: Every f and g result saturates to the symmetric range ±(2^(W−1)−1). Channel inputs may use the full two's-complement range.
- R5: `done` is high for exactly one cycle. That cycle begins at the 14th (2n−2) rising edge after the edge that sampled `load`.
- R6: The edge that samples `load` clears `bits_out` to 0. After `done`, `bits_out` holds its value until the next `load`, whatever `llr_in` and `frozen` do.
- R7: A `load` during a decode, including one on the edge of a bit decision, abandons that decode. The result and the timing are then those of the new vector alone.
- R8: For a noiseless codeword (LLR +M for x_i = 0, −M for x_i = 1) whose frozen positions carry 0, `bits_out[i]` equals u_i for every i.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load | input | 1 | Captures `llr_in` and `frozen` and starts a decode |
| llr_in | input | N*W | Channel LLRs, LLR i at bits [i*W +: W], two's complement |
| frozen | input | N | Bit i set marks u_i as frozen |
| bits_out | output | N | Decoded bits, bit i is u_i |
| done | output | 1 | One-cycle pulse when `bits_out` is complete |

## Verification
Two events can fall on the same clock edge: a stage-0 bit decision, which also updates the partial sums, and a fresh `load` that restarts the decoder. The bench provokes this by raising a second `load` so that it is sampled on the third edge of a running decode. That is the edge on which bit 0 of the first vector is decided. The outcome is judged against a bench reference decoder run on the second vector only, and the latency is counted from the second strobe. Separately, the same reference decoder covers random noisy vectors with random frozen masks, which exercises f, g and saturation together.

// File: rtl/sc_pkg.sv
package sc_pkg;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_FSTEP = 2'd1,
        S_GSTEP = 2'd2,
        S_FIN   = 2'd3
    } sc_state_e;

    typedef enum logic {
        OP_F = 1'b0,
        OP_G = 1'b1
    } pe_op_e;

endpackage

// File: rtl/sc_pe.sv
module sc_pe
    import sc_pkg::*;
#(
    parameter int W = 8
) (
    input  logic signed [W-1:0] a_i,
    input  logic signed [W-1:0] b_i,
    input  logic                ps_i,
    input  pe_op_e              op_i,
    output logic signed [W-1:0] y_o
);
    localparam logic signed [W:0] POS_LIM = (W+1)'((1 << (W-1)) - 1);
    localparam logic signed [W:0] NEG_LIM = -POS_LIM;

    logic signed [W:0] a_ext, b_ext, mag_a, mag_b, mag_min;
    logic signed [W:0] f_val, g_val, raw;

    always_comb begin
        a_ext   = {a_i[W-1], a_i};
        b_ext   = {b_i[W-1], b_i};
        mag_a   = a_i[W-1] ? -a_ext : a_ext;
        mag_b   = b_i[W-1] ? -b_ext : b_ext;
        mag_min = (mag_a < mag_b) ? mag_a : mag_b;
        f_val   = (a_i[W-1] ^ b_i[W-1]) ? -mag_min : mag_min;
        g_val   = ps_i ? (b_ext - a_ext) : (b_ext + a_ext);
        raw     = (op_i == OP_G) ? g_val : f_val;
        if (raw > POS_LIM) begin
            y_o = POS_LIM[W-1:0];
        end else if (raw < NEG_LIM) begin
            y_o = NEG_LIM[W-1:0];
        end else begin
            y_o = raw[W-1:0];
        end
    end

endmodule

// File: rtl/sc_psum.sv
module sc_psum #(
    parameter int IDX_W = 3,
    parameter int LVL   = 0
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clr_i,
    input  logic                     upd_i,
    input  logic [IDX_W-1:0]         idx_i,
    input  logic                     bit_i,
    output logic [(1 << LVL)-1:0]    ps_o
);
    localparam int WIDTH = 1 << LVL;
    localparam int SPAN  = 2 * WIDTH;
    localparam logic [IDX_W-1:0] KMASK = IDX_W'(SPAN - 1);
    localparam logic [IDX_W-1:0] KLIM  = IDX_W'(WIDTH);

    logic [IDX_W-1:0] pos;
    logic             in_left;

    assign pos     = idx_i & KMASK;
    assign in_left = (pos < KLIM);

    for (genvar j = 0; j < WIDTH; j++) begin : g_bit
        localparam logic [IDX_W-1:0] JV = IDX_W'(j);
        always_ff @(posedge clk) begin
            if (!rst_n || clr_i) begin
                ps_o[j] <= 1'b0;
            end else if (upd_i && in_left) begin
                if (pos == '0) begin
                    ps_o[j] <= (j == 0) ? bit_i : 1'b0;
                end else if ((pos & JV) == JV) begin
                    ps_o[j] <= ps_o[j] ^ bit_i;
                end
            end
        end
    end

endmodule

// File: rtl/sc_ctrl.sv
module sc_ctrl
    import sc_pkg::*;
#(
    parameter int M     = 3,
    parameter int LVL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    output logic [LVL_W-1:0] lvl_o,
    output pe_op_e           op_o,
    output logic             busy_o,
    output logic             decide_o,
    output logic [M-1:0]     idx_o,
    output logic             fin_o
);
    localparam int N = 1 << M;
    localparam logic [M-1:0]     LAST_IDX = M'(N - 1);
    localparam logic [LVL_W-1:0] TOP_LVL  = LVL_W'(M - 1);

    sc_state_e        state_q, state_d;
    logic [LVL_W-1:0] lvl_q, lvl_d;
    logic [M-1:0]     idx_q, idx_d, idx_inc;

    function automatic logic [LVL_W-1:0] entry_stage(input logic [M-1:0] v);
        logic [LVL_W-1:0] r;
        r = '0;
        for (int b = M - 1; b >= 0; b--) begin
            if (v[b]) r = LVL_W'(b);
        end
        return r;
    endfunction

    assign idx_inc = idx_q + 1'b1;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            lvl_q   <= '0;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            lvl_q   <= lvl_d;
            idx_q   <= idx_d;
        end
    end

    always_comb begin
        state_d = state_q;
        lvl_d   = lvl_q;
        idx_d   = idx_q;
        unique case (state_q)
            S_IDLE: begin
            end
            S_FSTEP, S_GSTEP: begin
                if (lvl_q != '0) begin
                    state_d = S_FSTEP;
                    lvl_d   = lvl_q - 1'b1;
                end else if (idx_q == LAST_IDX) begin
                    state_d = S_FIN;
                end else begin
                    state_d = S_GSTEP;
                    idx_d   = idx_inc;
                    lvl_d   = entry_stage(idx_inc);
                end
            end
            S_FIN: begin
                state_d = S_IDLE;
            end
        endcase
        if (load_i) begin
            state_d = S_FSTEP;
            lvl_d   = TOP_LVL;
            idx_d   = '0;
        end
    end

    always_comb begin
        busy_o   = (state_q == S_FSTEP) || (state_q == S_GSTEP);
        op_o     = (state_q == S_GSTEP) ? OP_G : OP_F;
        decide_o = busy_o && (lvl_q == '0);
        fin_o    = (state_q == S_FIN);
        lvl_o    = lvl_q;
        idx_o    = idx_q;
    end

endmodule

// File: rtl/sc_line_dec.sv
module sc_line_dec
    import sc_pkg::*;
#(
    parameter int M = 3,
    parameter int W = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       load,
    input  logic [(1 << M)*W-1:0]      llr_in,
    input  logic [(1 << M)-1:0]        frozen,
    output logic [(1 << M)-1:0]        bits_out,
    output logic                       done
);
    localparam int N     = 1 << M;
    localparam int HALF  = N / 2;
    localparam int TREE  = N - 2;
    localparam int LVL_W = (M > 2) ? $clog2(M) : 1;

    logic signed [W-1:0] ch_q   [N];
    logic signed [W-1:0] tree_q [TREE];
    logic [N-1:0]        frz_q;
    logic [N-1:0]        dec_q;
    logic [N-2:0]        ps_all;

    logic [LVL_W-1:0]    lvl;
    pe_op_e              op;
    logic                busy, decide, fin;
    logic [M-1:0]        idx;

    logic signed [W-1:0] pe_a [HALF];
    logic signed [W-1:0] pe_b [HALF];
    logic                pe_s [HALF];
    logic signed [W-1:0] pe_y [HALF];
    logic                u_bit;

    sc_ctrl #(.M(M), .LVL_W(LVL_W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (load),
        .lvl_o    (lvl),
        .op_o     (op),
        .busy_o   (busy),
        .decide_o (decide),
        .idx_o    (idx),
        .fin_o    (fin)
    );

    for (genvar l = 0; l < M; l++) begin : g_psum
        sc_psum #(.IDX_W(M), .LVL(l)) u_psum (
            .clk   (clk),
            .rst_n (rst_n),
            .clr_i (load),
            .upd_i (decide),
            .idx_i (idx),
            .bit_i (u_bit),
            .ps_o  (ps_all[(1 << l) - 1 +: (1 << l)])
        );
    end

    always_comb begin
        for (int p = 0; p < HALF; p++) begin
            pe_a[p] = '0;
            pe_b[p] = '0;
            pe_s[p] = 1'b0;
        end
        if (lvl == LVL_W'(M - 1)) begin
            for (int p = 0; p < HALF; p++) begin
                pe_a[p] = ch_q[p];
                pe_b[p] = ch_q[p + HALF];
                pe_s[p] = ps_all[HALF - 1 + p];
            end
        end
        for (int l = 0; l < M - 1; l++) begin
            if (lvl == LVL_W'(l)) begin
                for (int p = 0; p < (1 << l); p++) begin
                    pe_a[p] = tree_q[(1 << (l + 1)) - 2 + p];
                    pe_b[p] = tree_q[(1 << (l + 1)) - 2 + p + (1 << l)];
                    pe_s[p] = ps_all[(1 << l) - 1 + p];
                end
            end
        end
    end

    for (genvar p = 0; p < HALF; p++) begin : g_pe
        sc_pe #(.W(W)) u_pe (
            .a_i  (pe_a[p]),
            .b_i  (pe_b[p]),
            .ps_i (pe_s[p]),
            .op_i (op),
            .y_o  (pe_y[p])
        );
    end

    assign u_bit = frz_q[idx] ? 1'b0 : (pe_y[0][W-1] || (pe_y[0] == '0));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) ch_q[i] <= '0;
            frz_q <= '0;
        end else if (load) begin
            for (int i = 0; i < N; i++) ch_q[i] <= llr_in[i*W +: W];
            frz_q <= frozen;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int t = 0; t < TREE; t++) tree_q[t] <= '0;
        end else if (busy && !load) begin
            for (int l = 1; l < M; l++) begin
                if (lvl == LVL_W'(l)) begin
                    for (int p = 0; p < (1 << l); p++) begin
                        tree_q[(1 << l) - 2 + p] <= pe_y[p];
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || load) begin
            dec_q <= '0;
        end else if (decide) begin
            dec_q[idx] <= u_bit;
        end
    end

    assign bits_out = dec_q;
    assign done     = fin;

endmodule

// File: rtl/sc_line_dec_chk.sv
module sc_line_dec_chk #(
    parameter int M = 3,
    parameter int W = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                load,
    input logic [(1 << M)-1:0] frozen,
    input logic [(1 << M)-1:0] bits_out,
    input logic                done
);
    localparam int N     = 1 << M;
    localparam int CNT_W = $clog2(2 * N) + 1;
    localparam logic [CNT_W-1:0] STEPS = CNT_W'(2 * N - 2);

    logic             run_q;
    logic [CNT_W-1:0] cnt_q;
    logic [N-1:0]     frz_cap;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q   <= 1'b0;
            cnt_q   <= '0;
            frz_cap <= '0;
        end else if (load) begin
            run_q   <= 1'b1;
            cnt_q   <= '0;
            frz_cap <= frozen;
        end else if (run_q) begin
            cnt_q <= cnt_q + 1'b1;
            if (done) run_q <= 1'b0;
        end
    end

    // R5
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R5
    done_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (run_q && cnt_q == STEPS));

    // R3
    frozen_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ((bits_out & frz_cap) == '0));

    // R6
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_q && !load) |=> $stable(bits_out));

    // R6
    load_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (bits_out == '0));

endmodule

bind sc_line_dec sc_line_dec_chk #(.M(M), .W(W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .frozen   (frozen),
    .bits_out (bits_out),
    .done     (done)
);

// File: tb/tb_sc_line_dec.sv
module tb_sc_line_dec;
    localparam int M    = 3;
    localparam int W    = 8;
    localparam int N    = 1 << M;
    localparam int HALF = N / 2;
    localparam int LIM  = (1 << (W - 1)) - 1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             load = 1'b0;
    logic [N*W-1:0]   llr_in = '0;
    logic [N-1:0]     frozen = '0;
    logic [N-1:0]     bits_out;
    logic             done;

    int checks = 0;
    int errors = 0;

    sc_line_dec #(.M(M), .W(W)) dut (
        .clk(clk), .rst_n(rst_n), .load(load), .llr_in(llr_in),
        .frozen(frozen), .bits_out(bits_out), .done(done)
    );

    always #5 clk = ~clk;

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not finish (actual hung, expected completion)");
        $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, got, exp);
        end
    endtask

    function automatic int bsat(input int v);
        if (v > LIM) return LIM;
        if (v < -LIM) return -LIM;
        return v;
    endfunction

    function automatic int ctz_b(input int v);
        for (int b = 0; b < M; b++) if ((v >> b) & 1) return b;
        return M - 1;
    endfunction

    function automatic logic [N-1:0] ref_sc(input int ch [N], input logic [N-1:0] frz);
        int L [M][N];
        logic [N-1:0] u = '0;
        for (int i = 0; i < N; i++) begin
            int start = (i == 0) ? M - 1 : ctz_b(i);
            for (int l = start; l >= 0; l--) begin
                for (int j = 0; j < (1 << l); j++) begin
                    int a, b;
                    if (l == M - 1) begin
                        a = ch[j]; b = ch[j + HALF];
                    end else begin
                        a = L[l+1][j]; b = L[l+1][j + (1 << l)];
                    end
                    if (i != 0 && l == start) begin
                        int base = (i >> (l + 1)) << (l + 1);
                        logic s = 1'b0;
                        for (int k = base; k < base + (1 << l); k++)
                            if (((k - base) & j) == j) s ^= u[k];
                        L[l][j] = bsat(s ? b - a : b + a);
                    end else begin
                        int ma = (a < 0) ? -a : a;
                        int mb = (b < 0) ? -b : b;
                        int mn = (ma < mb) ? ma : mb;
                        L[l][j] = bsat(((a < 0) != (b < 0)) ? -mn : mn);
                    end
                end
            end
            u[i] = frz[i] ? 1'b0 : (L[0][0] <= 0);
        end
        return u;
    endfunction

    function automatic logic [N-1:0] encode(input logic [N-1:0] u);
        logic [N-1:0] x = '0;
        for (int j = 0; j < N; j++)
            for (int k = 0; k < N; k++)
                if ((k & j) == j) x[j] ^= u[k];
        return x;
    endfunction

    task automatic drive(input int ch [N], input logic [N-1:0] frz);
        for (int i = 0; i < N; i++) llr_in[i*W +: W] = W'(ch[i]);
        frozen = frz;
        load = 1'b1;
    endtask

    // called just after a negedge; leaves the bench just after the negedge on which done is seen
    task automatic run_dec(input int ch [N], input logic [N-1:0] frz, input string req,
                           input bit chk_clear, output int lat);
        drive(ch, frz);
        @(negedge clk);
        load = 1'b0;
        if (chk_clear) check("R6 clear on load", 32'(bits_out), 32'd0);
        lat = 0;
        while (!done && lat < 60) begin
            @(negedge clk);
            lat++;
        end
        check({req, " latency"}, 32'(lat), 32'(2 * N - 2));
    endtask

    task automatic expect_vec(input int ch [N], input logic [N-1:0] frz, input string req);
        int lat;
        run_dec(ch, frz, req, 1'b0, lat);
        check(req, 32'(bits_out), 32'(ref_sc(ch, frz)));
    endtask

    function automatic int clamp8(input int v);
        if (v > LIM) return LIM;
        if (v < -LIM - 1) return -LIM - 1;
        return v;
    endfunction

    initial begin
        int ch [N];
        int chb [N];
        int lat;
        logic [N-1:0] u, frz, x, held;
        void'($urandom(32'd20240611));

        repeat (3) @(negedge clk);
        check("R6 reset bits_out", 32'(bits_out), 32'd0);
        check("R5 reset done", 32'(done), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R8 all-positive channel decodes to zeros
        for (int i = 0; i < N; i++) ch[i] = 50;
        expect_vec(ch, '0, "R8 all positive");
        check("R8 zeros", 32'(bits_out), 32'd0);
        @(negedge clk);
        check("R5 done one cycle", 32'(done), 32'd0);

        // R8 all-negative channel: only u7 set
        for (int i = 0; i < N; i++) ch[i] = -50;
        run_dec(ch, '0, "R8 all negative", 1'b1, lat);
        check("R8 all negative", 32'(bits_out), 32'h80);

        // R3 fully frozen
        expect_vec(ch, '1, "R3 all frozen");
        check("R3 all frozen zero", 32'(bits_out), 32'd0);

        // R3 zero LLRs decide 1 where not frozen
        for (int i = 0; i < N; i++) ch[i] = 0;
        expect_vec(ch, 8'h0F, "R3 zero llr");
        check("R3 zero llr value", 32'(bits_out), 32'hF0);

        // R4 extreme inputs, g sums overflow
        for (int i = 0; i < N; i++) ch[i] = (i % 3 == 0) ? -LIM - 1 : LIM;
        expect_vec(ch, '0, "R4 extremes");
        for (int i = 0; i < N; i++) ch[i] = LIM;
        expect_vec(ch, '0, "R4 positive rail");

        // R1 f with mixed signs and magnitudes
        ch = '{3, -9, 12, -1, -5, 7, -20, 4};
        expect_vec(ch, 8'h01, "R1 directed f");
        // R2 g sign-controlled
        ch = '{-6, 2, -30, 8, -4, 11, 15, -3};
        expect_vec(ch, 8'h00, "R2 directed g");

        // R8 noiseless random codewords
        for (int t = 0; t < 20; t++) begin
            frz = N'($urandom);
            u = N'($urandom) & ~frz;
            x = encode(u);
            for (int i = 0; i < N; i++) ch[i] = x[i] ? -(1 + $urandom % 60) : (1 + $urandom % 60);
            run_dec(ch, frz, "R8 noiseless", 1'b0, lat);
            check("R8 noiseless", 32'(bits_out), 32'(u));
        end

        // R1 R2 R4 noisy random vs reference
        for (int t = 0; t < 40; t++) begin
            frz = N'($urandom) & N'($urandom);
            u = N'($urandom) & ~frz;
            x = encode(u);
            for (int i = 0; i < N; i++) begin
                int mag = 1 + $urandom % 90;
                int nz = int'($urandom % 121) - 60;
                ch[i] = clamp8((x[i] ? -mag : mag) + nz);
            end
            expect_vec(ch, frz, "R1 R2 R4 noisy");
        end

        // R6 result held while inputs change
        held = bits_out;
        for (int c = 0; c < 20; c++) begin
            llr_in = {$urandom, $urandom};
            frozen = N'($urandom);
            @(negedge clk);
            if (done) check("R5 no extra done", 32'(done), 32'd0);
        end
        check("R6 held result", 32'(bits_out), 32'(held));

        // R7 restart on the edge of the first decision
        ch = '{40, -35, 22, -18, 9, -50, 31, 5};
        chb = '{-12, 27, -44, 6, 19, -8, -33, 14};
        drive(ch, '0);
        @(negedge clk);
        load = 1'b0;
        @(negedge clk);
        @(negedge clk);
        run_dec(chb, 8'h11, "R7 restart", 1'b0, lat);
        check("R7 restart result", 32'(bits_out), 32'(ref_sc(chb, 8'h11)));
        @(negedge clk);
        check("R7 single done", 32'(done), 32'd0);

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule